// File: doc/BRIEF.md
# Interprocessor Interrupt Command Register

This block is the command register pair of a local interrupt controller, seen by software as three 32-bit words on a simple register bus. Software first stages a target controller ID in the high command word. It then writes the low command word. That low-word write carries the delivery mode, the level bit and the vector, and it launches exactly one interrupt message. A read-only word reports the controller's own ID, which is taken from a static strap input.

A launched message is presented on an outgoing port with a valid/ready handshake. It is held steady until the port accepts it, and a busy flag in the low word is visible to software for that whole time. There is one exception. When the message is an NMI addressed to the controller's own ID, it never leaves the block: it raises a one-cycle local NMI pulse instead.

Top module: `ipi_cmd_regs`

## Requirements
- R1: After reset, the low and high command words read 0, `msg_valid` is 0 and `local_nmi` is 0.
- R2: A read of offset 0x20 returns the `local_id` strap in bits 31:24 and 0 in all other bits.
- R3: A full write to offset 0x310 stores the target ID in bits 31:24 of the high word. It launches no message.
- R4: A full write to offset 0x300 launches one message. From the next cycle, `msg_valid` is 1 and the port carries the following fields: target = high-word bits 31:24, mode = low bits 10:8, level = low bit 14, and vector = low bits 7:0.
- R5: When mode is 3'b100 (NMI), the vector on the port is 0. For any other mode, the vector on the port is the written vector.
- R6: Reserved bits are never changed by a write and read back as 0. These are low-word bits 13, 16, 17 and 31:20, and high-word bits 23:0. Low-word bits 11, 15, 18 and 19 are stored and read back.
- R7: A write whose byte enables are not all 4'hF changes no register and launches nothing.
- R8: Low-word bit 12 reads 1 from the cycle after a launch until the cycle after the port accepts the message (`msg_valid && msg_ready`). While the message waits, its fields stay stable.
- R9: A low-word write while bit 12 is 1 is dropped. The stored low word is unchanged and no further message is sent.
- R10: When mode is NMI and the target equals `local_id`, `local_nmi` is 1 for exactly one cycle, starting the cycle after the write. No message appears on the port and bit 12 stays 0.
- R11: A high-word write while a message is pending does not alter the pending message's target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| local_id | input | 8 | Static strap giving this controller's ID |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset of the access |
| bus_be | input | 4 | Byte enables; only 4'hF writes take effect |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| msg_valid | output | 1 | Outgoing message present |
| msg_ready | input | 1 | Port accepts the message |
| msg_dest | output | 8 | Message target ID |
| msg_mode | output | 3 | Message delivery mode |
| msg_level | output | 1 | Message level bit |
| msg_vector | output | 8 | Message vector (0 for NMI) |
| local_nmi | output | 1 | One-cycle pulse for a self-targeted NMI |

## Verification
Register reads are combinational. The bench presents the address half a period before an edge and samples 1 ns later. Every write takes effect at the next rising edge, so `msg_valid`, `local_nmi`, the busy bit and the stored words are all due in the cycle right after the write. The bench samples them just after the following falling edge. Acceptance completes on the edge where `msg_valid && msg_ready` is seen. The scoreboard monitor therefore compares the message just after a falling edge where both are high, and it expects the busy bit to be clear one cycle later.

// File: rtl/ipi_cmd_pkg.sv
// Shared field positions, masks and message type for the interrupt command
// register block. Assumes a 32-bit register word.
package ipi_cmd_pkg;
    localparam int WORD_W = 32;
    localparam int DEST_W = 8;
    localparam int MODE_W = 3;
    localparam int VEC_W  = 8;

    localparam int VEC_LSB   = 0;
    localparam int MODE_LSB  = 8;
    localparam int BUSY_BIT  = 12;
    localparam int LEVEL_BIT = 14;
    localparam int DEST_LSB  = WORD_W - DEST_W;

    localparam logic [MODE_W-1:0] MODE_NMI = 3'b100;

    // Writable bits of each command word; everything else is reserved or status.
    localparam logic [WORD_W-1:0] LOW_WMASK  = 32'h000C_CFFF;
    localparam logic [WORD_W-1:0] HIGH_WMASK = 32'hFF00_0000;

    typedef struct packed {
        logic [DEST_W-1:0] dest;
        logic [MODE_W-1:0] mode;
        logic              level;
        logic [VEC_W-1:0]  vector;
    } ipi_msg_t;
endpackage

// File: rtl/ipi_bus_decode.sv
// Address decode for the three register words. Assumes single-cycle accesses
// and accepts a write only when all four byte enables are set.
module ipi_bus_decode #(
    parameter int          ADDR_W = 12,
    parameter int          BE_W   = 4,
    parameter logic [11:0] OFS_ID = 12'h020,
    parameter logic [11:0] OFS_LO = 12'h300,
    parameter logic [11:0] OFS_HI = 12'h310
) (
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BE_W-1:0]   bus_be,
    output logic              hit_id,
    output logic              hit_lo,
    output logic              hit_hi,
    output logic              wr_lo,
    output logic              wr_hi
);
    logic full_wr;

    // Match the offset of each register word.
    always_comb begin
        hit_id = (bus_addr == ADDR_W'(OFS_ID));
        hit_lo = (bus_addr == ADDR_W'(OFS_LO));
        hit_hi = (bus_addr == ADDR_W'(OFS_HI));
    end

    // Qualify writes: selected, write cycle, full word.
    always_comb begin
        full_wr = bus_sel && bus_wr && (bus_be == {BE_W{1'b1}});
        wr_lo   = full_wr && hit_lo;
        wr_hi   = full_wr && hit_hi;
    end
endmodule

// File: rtl/ipi_cmd_store.sv
// Holds the two command words. Only writable bits change on a write; reserved
// bits keep their stored value. Assumes the low write is already gated by busy.
module ipi_cmd_store #(
    parameter int          WORD_W = 32,
    parameter logic [31:0] LO_MASK = 32'h000C_CFFF,
    parameter logic [31:0] HI_MASK = 32'hFF00_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] low_q,
    output logic [WORD_W-1:0] high_q
);
    localparam logic [WORD_W-1:0] LM = WORD_W'(LO_MASK);
    localparam logic [WORD_W-1:0] HM = WORD_W'(HI_MASK);

    // Low command word: merge writable bits, keep reserved bits.
    always_ff @(posedge clk) begin
        if (!rst_n)
            low_q <= '0;
        else if (wr_lo)
            low_q <= (low_q & ~LM) | (wdata & LM);
    end

    // High command word: only the target field is writable.
    always_ff @(posedge clk) begin
        if (!rst_n)
            high_q <= '0;
        else if (wr_hi)
            high_q <= (high_q & ~HM) | (wdata & HM);
    end
endmodule

// File: rtl/ipi_launch.sv
// Launch sequencer: captures a message on a low-word write and holds it on the
// outgoing port until accepted. A self-targeted NMI becomes a one-cycle local
// pulse instead. Assumes launch is asserted only while not busy.
module ipi_launch
    import ipi_cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch,
    input  logic [DEST_W-1:0] dest_in,
    input  logic [MODE_W-1:0] mode_in,
    input  logic              level_in,
    input  logic [VEC_W-1:0]  vec_in,
    input  logic [DEST_W-1:0] local_id,
    input  logic              msg_ready,
    output logic              msg_valid,
    output ipi_msg_t          msg,
    output logic              local_nmi
);
    logic is_nmi;
    logic to_self;

    // Classify the requested message.
    always_comb begin
        is_nmi  = (mode_in == MODE_NMI);
        to_self = is_nmi && (dest_in == local_id);
    end

    // Pending message register and handshake completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            msg_valid <= 1'b0;
            msg       <= '0;
        end else if (launch && !to_self) begin
            msg_valid  <= 1'b1;
            msg.dest   <= dest_in;
            msg.mode   <= mode_in;
            msg.level  <= level_in;
            msg.vector <= is_nmi ? '0 : vec_in;
        end else if (msg_valid && msg_ready) begin
            msg_valid <= 1'b0;
        end
    end

    // Single-cycle local NMI for a self-targeted NMI launch.
    always_ff @(posedge clk) begin
        if (!rst_n)
            local_nmi <= 1'b0;
        else
            local_nmi <= launch && to_self;
    end
endmodule

// File: rtl/ipi_cmd_regs.sv
// Top of the interprocessor interrupt command register block: bus decode,
// command storage, launch sequencing and read-back mux with busy status.
module ipi_cmd_regs
    import ipi_cmd_pkg::*;
#(
    parameter int          ADDR_W = 12,
    parameter int          BE_W   = 4,
    parameter logic [11:0] OFS_ID = 12'h020,
    parameter logic [11:0] OFS_LO = 12'h300,
    parameter logic [11:0] OFS_HI = 12'h310
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DEST_W-1:0] local_id,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BE_W-1:0]   bus_be,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    output logic              msg_valid,
    input  logic              msg_ready,
    output logic [DEST_W-1:0] msg_dest,
    output logic [MODE_W-1:0] msg_mode,
    output logic              msg_level,
    output logic [VEC_W-1:0]  msg_vector,
    output logic              local_nmi
);
    logic              hit_id, hit_lo, hit_hi;
    logic              wr_lo, wr_hi, wr_lo_ok;
    logic [WORD_W-1:0] low_q, high_q;
    ipi_msg_t          msg;

    ipi_bus_decode #(
        .ADDR_W(ADDR_W), .BE_W(BE_W),
        .OFS_ID(OFS_ID), .OFS_LO(OFS_LO), .OFS_HI(OFS_HI)
    ) u_dec (
        .bus_sel (bus_sel),
        .bus_wr  (bus_wr),
        .bus_addr(bus_addr),
        .bus_be  (bus_be),
        .hit_id  (hit_id),
        .hit_lo  (hit_lo),
        .hit_hi  (hit_hi),
        .wr_lo   (wr_lo),
        .wr_hi   (wr_hi)
    );

    // A low write is honoured only when no message is pending.
    always_comb wr_lo_ok = wr_lo && !msg_valid;

    ipi_cmd_store #(
        .WORD_W(WORD_W), .LO_MASK(LOW_WMASK), .HI_MASK(HIGH_WMASK)
    ) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_lo (wr_lo_ok),
        .wr_hi (wr_hi),
        .wdata (bus_wdata),
        .low_q (low_q),
        .high_q(high_q)
    );

    ipi_launch u_launch (
        .clk      (clk),
        .rst_n    (rst_n),
        .launch   (wr_lo_ok),
        .dest_in  (high_q[DEST_LSB +: DEST_W]),
        .mode_in  (bus_wdata[MODE_LSB +: MODE_W]),
        .level_in (bus_wdata[LEVEL_BIT]),
        .vec_in   (bus_wdata[VEC_LSB +: VEC_W]),
        .local_id (local_id),
        .msg_ready(msg_ready),
        .msg_valid(msg_valid),
        .msg      (msg),
        .local_nmi(local_nmi)
    );

    // Drive the outgoing message fields.
    always_comb begin
        msg_dest   = msg.dest;
        msg_mode   = msg.mode;
        msg_level  = msg.level;
        msg_vector = msg.vector;
    end

    // Read-back mux; the busy flag is merged into the low word.
    always_comb begin
        bus_rdata = '0;
        if (hit_id) begin
            bus_rdata[DEST_LSB +: DEST_W] = local_id;
        end else if (hit_lo) begin
            bus_rdata           = low_q;
            bus_rdata[BUSY_BIT] = msg_valid;
        end else if (hit_hi) begin
            bus_rdata = high_q;
        end
    end
endmodule

// File: rtl/ipi_cmd_regs_chk.sv
// Protocol checker for ipi_cmd_regs, bound to every instance of the top.
module ipi_cmd_regs_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       bus_sel,
    input logic       bus_wr,
    input logic [3:0] bus_be,
    input logic       msg_valid,
    input logic       msg_ready,
    input logic [7:0] msg_dest,
    input logic [2:0] msg_mode,
    input logic       msg_level,
    input logic [7:0] msg_vector,
    input logic       local_nmi
);
    // R8
    msg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_dest) &&
            $stable(msg_mode) && $stable(msg_level) && $stable(msg_vector)));

    // R5
    nmi_vec_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && msg_mode == 3'b100) |-> (msg_vector == 8'h00));

    // R7
    partial_no_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_be != 4'hF) |=> (!$rose(msg_valid) && !local_nmi));

    // R10
    nmi_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        local_nmi |=> !local_nmi);

    // R10
    nmi_not_sent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        local_nmi |-> !msg_valid);
endmodule

bind ipi_cmd_regs ipi_cmd_regs_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_be    (bus_be),
    .msg_valid (msg_valid),
    .msg_ready (msg_ready),
    .msg_dest  (msg_dest),
    .msg_mode  (msg_mode),
    .msg_level (msg_level),
    .msg_vector(msg_vector),
    .local_nmi (local_nmi)
);

// File: tb/ipi_cmd_regs_test.sv
// Scoreboard bench: driver tasks queue expected messages, a monitor compares
// accepted port traffic against the queue.
module ipi_cmd_regs_test;
    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] MY_ID = 8'h05;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  local_id = MY_ID;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [3:0]  bus_be = 4'hF;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        msg_valid, msg_ready = 1'b0;
    logic [7:0]  msg_dest, msg_vector;
    logic [2:0]  msg_mode;
    logic        msg_level, local_nmi;

    int checks = 0, fails = 0;
    bit done = 1'b0;
    logic [19:0] exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    ipi_cmd_regs uut (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic [3:0] be = 4'hF);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_be = be;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; bus_be = 4'hF;
        #1;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    // Driver helper: queue the message a launch is expected to produce.
    task automatic expect_msg(input logic [7:0] dst, input logic [2:0] md,
                              input logic lv, input logic [7:0] vc);
        exp_q.push_back({dst, md, lv, vc});
    endtask

    task automatic drain();
        for (int i = 0; i < 50 && exp_q.size() != 0; i++) @(negedge clk);
        chk("R4 drain", 32'(exp_q.size()), 32'd0);
        @(negedge clk); #1;
    endtask

    // Monitor: compare each accepted message against the scoreboard queue.
    initial forever begin
        @(negedge clk); #1;
        if (rst_n && msg_valid && msg_ready) begin
            if (exp_q.size() == 0) chk("R4 unexpected msg", {12'd0, msg_dest, msg_mode, msg_level, msg_vector}, 32'hFFFFFFFF);
            else chk("R4 R5 msg fields", {12'd0, msg_dest, msg_mode, msg_level, msg_vector}, {12'd0, exp_q.pop_front()});
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk("R1 valid", {31'd0, msg_valid}, 0);
        chk("R1 nmi", {31'd0, local_nmi}, 0);
        rd(12'h300, d); chk("R1 low", d, 0);
        rd(12'h310, d); chk("R1 high", d, 0);
        // R2 local id
        rd(12'h020, d); chk("R2 id", d, 32'h0500_0000);
        // R3 staging only
        wr(12'h310, 32'h2A00_0000);
        chk("R3 no launch", {31'd0, msg_valid}, 0);
        rd(12'h310, d); chk("R3 high", d, 32'h2A00_0000);
        // R4 fixed-mode launch with port stalled
        expect_msg(8'h2A, 3'b000, 1'b0, 8'h31);
        wr(12'h300, 32'h0000_0031);
        chk("R4 valid", {31'd0, msg_valid}, 1);
        rd(12'h300, d); chk("R8 busy", d, 32'h0000_1031);
        // R11 restage during pending message
        wr(12'h310, 32'h3B00_0000);
        chk("R11 dest held", {24'd0, msg_dest}, 32'h2A);
        // R9 dropped low write
        wr(12'h300, 32'h0000_4477);
        rd(12'h300, d); chk("R9 low kept", d, 32'h0000_1031);
        msg_ready = 1'b1;
        drain();
        rd(12'h300, d); chk("R8 busy clear", d, 32'h0000_0031);
        chk("R9 no extra", {31'd0, msg_valid}, 0);
        // R5 NMI to other controller, vector suppressed
        expect_msg(8'h3B, 3'b100, 1'b1, 8'h00);
        wr(12'h300, 32'h0000_4455);
        drain();
        // R6 reserved bits
        wr(12'h310, 32'hFFFF_FFFF);
        rd(12'h310, d); chk("R6 high", d, 32'hFF00_0000);
        expect_msg(8'hFF, 3'b111, 1'b1, 8'hFF);
        wr(12'h300, 32'hFFFF_FFFF);
        drain();
        rd(12'h300, d); chk("R6 low", d, 32'h000C_CFFF);
        // R7 partial writes ignored
        wr(12'h300, 32'h0000_0022, 4'b0111);
        chk("R7 no launch", {31'd0, msg_valid}, 0);
        rd(12'h300, d); chk("R7 low", d, 32'h000C_CFFF);
        wr(12'h310, 32'h1100_0000, 4'b1000);
        rd(12'h310, d); chk("R7 high", d, 32'hFF00_0000);
        // R10 self NMI
        wr(12'h310, 32'h0500_0000);
        wr(12'h300, 32'h0000_4400);
        chk("R10 pulse", {31'd0, local_nmi}, 1);
        chk("R10 not sent", {31'd0, msg_valid}, 0);
        rd(12'h300, d); chk("R10 busy", d, 32'h0000_4400);
        chk("R10 one cycle", {31'd0, local_nmi}, 0);
        // R10 fixed mode to self still goes out on the port
        expect_msg(8'h05, 3'b000, 1'b0, 8'h40);
        wr(12'h300, 32'h0000_0040);
        chk("R10 fixed no nmi", {31'd0, local_nmi}, 0);
        drain();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule